// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading 64-bit page table entries from memory, one level per read. A configuration input picks the address-space size (three, four or five levels) and supplies the page number of the root table. Each table is 4 KiB and holds 512 entries, so every level takes 9 virtual address bits above the 12-bit page offset.

A translation is requested on a valid/ready port. Only one walk runs at a time. The walker issues single-beat reads on a simple request/response memory port and decodes each returned entry. An entry can point to the next table, or it can be a leaf at any level. At the lowest level, an entry can also stand for a 64 KiB contiguous region.

The walker returns the physical address, the seven permission and status bits, and a fault flag. It holds these until they are accepted. Bad configuration codes and non-canonical addresses fault at once, without any memory traffic.

Top module: `ptw_walker`

## Requirements
- R1: The mode code sets the top level to the code minus 6: code 8 gives three levels (39-bit VA), 9 gives four (48-bit), 10 gives five (57-bit). Any other code answers with a fault and issues no memory read.
- R2: Bits 63 down to (VA width − 1) of the virtual address must all be equal. Otherwise the walk faults with no memory read.
- R3: The first read goes to root_ppn·4096 + 8·index(top). The index for level L is VA[12+9L+8 : 12+9L]. Every read address is 8-byte aligned.
- R4: An entry whose bit 0 (valid) is clear ends the walk with a fault.
- R5: An entry is a pointer when it is valid, sits at a level above 0, and has bits 3:1 (X, W, R) all zero. The next read uses base PTE[53:10]·4096 at one level lower.
- R6: A valid entry is a leaf when it sits at level 0 or has any of bits 3:1 set. For a leaf at level L, the PA takes bits at and above 12+9L from PTE[53:10]·4096, and the lower bits from the VA.
- R7: At level 0, with the contiguity enable high and bit 63 set, the PA is {PTE[53:14], VA[15:0]}. With the enable low, bit 63 is ignored and the normal 4 KiB formula applies.
- R8: An entry with bit 63 set at any level above 0 faults, whether it is a leaf or a pointer.
- R9: The permission output is PTE[7:1] (bit 0 = R, then W, X, U, G, A, D). A faulting response carries a zero PA and zero permissions.
- R10: req_ready_o is high only when idle. A response stays valid and stable until rsp_ready_i is high. A memory request keeps its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 4 | Address-space mode code |
| cfg_root_ppn_i | input | 44 | Page number of the root table |
| cfg_contig_en_i | input | 1 | Enables 64 KiB contiguous leaves at level 0 |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address to translate |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_pa_o | output | 56 | Translated physical address |
| rsp_perm_o | output | 7 | R, W, X, U, G, A, D from the leaf (bit 0 = R) |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 56 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |

## Verification
The bench sweeps every mode against every leaf level. A design that gets the split between PTE bits and VA bits wrong returns a PA whose page-offset boundary sits at the wrong bit. An off-by-one level count shows up as the wrong number of reads.

An invalid entry is placed at each depth in turn, and the bench checks that the walk stops after exactly the right number of reads. Non-canonical addresses and unsupported mode codes must fault with zero reads; a design that skips these checks would start reading memory.

Contiguous entries are walked with the enable both on and off, and a flagged entry is planted above level 0. A design that ignores the enable, or accepts the flag at a high level, returns the wrong PA instead of a fault. Memory stalls and a held-off response check that addresses and results stay stable.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned VA_W       = 64;
  parameter int unsigned PTE_W      = 64;
  parameter int unsigned PPN_W      = 44;
  parameter int unsigned PG_LG2     = 12;
  parameter int unsigned IDX_W      = 9;
  parameter int unsigned MAX_LVL    = 4;
  parameter int unsigned CONTIG_LG2 = 16;
  parameter int unsigned PERM_W     = 7;

  localparam int unsigned PA_W    = PPN_W + PG_LG2;
  localparam int unsigned LVL_W   = $clog2(MAX_LVL + 1);
  localparam int unsigned ENT_LG2 = $clog2(PTE_W / 8);
  localparam int unsigned CG_W    = CONTIG_LG2 - PG_LG2;

  typedef struct packed {
    logic             n;
    logic [1:0]       mtype;
    logic [6:0]       rsv;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       rsw;
    logic             d;
    logic             a;
    logic             g;
    logic             u;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;

  typedef enum logic [1:0] {K_EMPTY, K_PTR, K_LEAF, K_BAD} pte_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_MWAIT, S_RSP} walk_st_e;
endpackage

// File: rtl/ptw_mode_dec.sv
module ptw_mode_dec
  import ptw_pkg::*;
#(
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned MODE_BIAS = 6,
  parameter int unsigned MIN_TOP   = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic              ok_o,
  output logic [LVL_W-1:0]  top_o
);
  localparam logic [MODE_W-1:0] MODE_LO = MODE_W'(MODE_BIAS + MIN_TOP);
  localparam logic [MODE_W-1:0] MODE_HI = MODE_W'(MODE_BIAS + MAX_LVL);
  localparam logic [MODE_W-1:0] BIAS    = MODE_W'(MODE_BIAS);

  logic [MODE_W-1:0] diff;

  always_comb begin
    ok_o  = (mode_i >= MODE_LO) && (mode_i <= MODE_HI);
    diff  = mode_i - BIAS;
    top_o = ok_o ? diff[LVL_W-1:0] : '0;
  end
endmodule

// File: rtl/ptw_va_chk.sv
module ptw_va_chk
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  chk_va_i,
  input  logic [LVL_W-1:0] top_i,
  input  logic [VA_W-1:0]  walk_va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             canon_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [MAX_LVL:0]   canon_t;
  logic [IDX_W-1:0]   idx_t [MAX_LVL+1];
  logic               unused_va;

  for (genvar t = 0; t <= MAX_LVL; t++) begin : g_lvl
    localparam int unsigned MSB = PG_LG2 + IDX_W * (t + 1) - 1;
    // upper bits must replicate the top implemented bit
    assign canon_t[t] = (&chk_va_i[VA_W-1:MSB]) | ~(|chk_va_i[VA_W-1:MSB]);
    assign idx_t[t]   = walk_va_i[PG_LG2 + IDX_W * t +: IDX_W];
  end

  assign unused_va = ^{walk_va_i[VA_W-1:PG_LG2+IDX_W*(MAX_LVL+1)], walk_va_i[PG_LG2-1:0]};

  always_comb begin
    canon_o = 1'b0;
    idx_o   = '0;
    for (int t = 0; t <= MAX_LVL; t++) begin
      if (top_i == LVL_W'(t)) canon_o = canon_t[t];
      if (lvl_i == LVL_W'(t)) idx_o = idx_t[t];
    end
  end
endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]  pte_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              contig_en_i,
  input  logic [PA_W-1:0]   va_i,
  output pte_kind_e         kind_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [PERM_W-1:0] perm_o,
  output logic [PA_W-1:0]   next_base_o
);
  pte_t            pte;
  logic            at_bottom;
  logic            rwx;
  logic            use_contig;
  logic [PA_W-1:0] base_pa;
  logic [PA_W-1:0] lo_mask;
  logic            unused_pte;

  assign pte        = pte_t'(pte_i);
  assign at_bottom  = (lvl_i == '0);
  assign rwx        = pte.r | pte.w | pte.x;
  assign use_contig = at_bottom & pte.n & contig_en_i;
  assign base_pa    = {pte.ppn, {PG_LG2{1'b0}}};
  assign unused_pte = ^{pte.mtype, pte.rsv, pte.rsw};

  always_comb begin
    lo_mask = '0;
    for (int t = 0; t <= MAX_LVL; t++)
      if (lvl_i == LVL_W'(t)) lo_mask = ~({PA_W{1'b1}} << (PG_LG2 + IDX_W * t));
  end

  always_comb begin
    if (!pte.v)                   kind_o = K_EMPTY;
    else if (pte.n && !at_bottom) kind_o = K_BAD;
    else if (rwx || at_bottom)    kind_o = K_LEAF;
    else                          kind_o = K_PTR;
  end

  always_comb begin
    if (use_contig) pa_o = {pte.ppn[PPN_W-1:CG_W], va_i[CONTIG_LG2-1:0]};
    else            pa_o = (base_pa & ~lo_mask) | (va_i & lo_mask);
  end

  assign perm_o      = {pte.d, pte.a, pte.g, pte.u, pte.x, pte.w, pte.r};
  assign next_base_o = base_pa;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [PPN_W-1:0]  cfg_root_ppn_i,
  input  logic              cfg_contig_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [PERM_W-1:0] rsp_perm_o,
  output logic              rsp_fault_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i
);
  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   base_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   pa_q;
  logic [PERM_W-1:0] perm_q;
  logic              fault_q;

  logic              mode_ok;
  logic [LVL_W-1:0]  mode_top;
  logic              canon;
  logic [IDX_W-1:0]  idx;
  pte_kind_e         kind;
  logic [PA_W-1:0]   leaf_pa;
  logic [PERM_W-1:0] leaf_perm;
  logic [PA_W-1:0]   next_base;

  ptw_mode_dec #(.MODE_W(MODE_W)) i_mode_dec (
    .mode_i (cfg_mode_i),
    .ok_o   (mode_ok),
    .top_o  (mode_top)
  );

  ptw_va_chk i_va_chk (
    .chk_va_i  (req_va_i),
    .top_i     (mode_top),
    .walk_va_i (va_q),
    .lvl_i     (lvl_q),
    .canon_o   (canon),
    .idx_o     (idx)
  );

  ptw_pte_dec i_pte_dec (
    .pte_i       (mem_rsp_data_i),
    .lvl_i       (lvl_q),
    .contig_en_i (cfg_contig_en_i),
    .va_i        (va_q[PA_W-1:0]),
    .kind_o      (kind),
    .pa_o        (leaf_pa),
    .perm_o      (leaf_perm),
    .next_base_o (next_base)
  );

  assign req_ready_o     = (st_q == S_IDLE);
  assign mem_req_valid_o = (st_q == S_MREQ);
  assign mem_req_addr_o  = base_q + PA_W'({idx, {ENT_LG2{1'b0}}});
  assign rsp_valid_o     = (st_q == S_RSP);
  assign rsp_pa_o        = pa_q;
  assign rsp_perm_o      = perm_q;
  assign rsp_fault_o     = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i;
          lvl_q  <= mode_top;
          base_q <= {cfg_root_ppn_i, {PG_LG2{1'b0}}};
          pa_q   <= '0;
          perm_q <= '0;
          if (!mode_ok || !canon) begin
            fault_q <= 1'b1;
            st_q    <= S_RSP;
          end else begin
            fault_q <= 1'b0;
            st_q    <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready_i) st_q <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid_i) begin
          unique case (kind)
            K_PTR: begin
              base_q <= next_base;
              lvl_q  <= lvl_q - 1'b1;
              st_q   <= S_MREQ;
            end
            K_LEAF: begin
              pa_q    <= leaf_pa;
              perm_q  <= leaf_perm;
              fault_q <= 1'b0;
              st_q    <= S_RSP;
            end
            default: begin
              fault_q <= 1'b1;
              st_q    <= S_RSP;
            end
          endcase
        end
        S_RSP: if (rsp_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [PA_W-1:0]   rsp_pa_o,
  input logic [PERM_W-1:0] rsp_perm_o,
  input logic              rsp_fault_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [PA_W-1:0]   mem_req_addr_o
);
  AST_MREQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R10
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o)
      && $stable(rsp_perm_o) && $stable(rsp_fault_o)); // R10
  AST_MREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R10
  AST_MREQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000); // R3
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == '0 && rsp_perm_o == '0); // R9
  AST_RSP_NO_MREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o); // R10
endmodule

bind ptw_walker ptw_walker_chk i_ptw_walker_chk (.*);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_mode = 4'd8;
  logic [43:0] cfg_root = '0;
  logic        cfg_contig = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [55:0] rsp_pa;
  logic [6:0]  rsp_perm;
  logic        rsp_fault;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [55:0] mreq_addr;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  always #2 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .cfg_root_ppn_i(cfg_root),
    .cfg_contig_en_i(cfg_contig), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_pa_o(rsp_pa), .rsp_perm_o(rsp_perm), .rsp_fault_o(rsp_fault),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data)
  );

  int n_chk = 0, n_fail = 0, reads = 0, mem_stall = 0;
  logic [63:0] first_addr, r_pa, r_perm, r_fault;
  logic [63:0] mem [logic [63:0]];
  localparam logic [63:0] PA_MASK = 64'h00FF_FFFF_FFFF_FFFF;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int vaw(int top); return 12 + 9 * (top + 1); endfunction
  function automatic logic [63:0] sx(logic [63:0] v, int w);
    logic [63:0] m = ~64'h0 << w;
    return v[w-1] ? (v | m) : (v & ~m);
  endfunction
  function automatic logic [63:0] idx(logic [63:0] va, int l);
    return (va >> (12 + 9 * l)) & 64'h1FF;
  endfunction
  function automatic logic [63:0] tbl(int l); return 64'h40000 + 64'(l) * 64'h11; endfunction
  function automatic logic [63:0] ent_addr(logic [63:0] va, int l);
    return (tbl(l) << 12) + 8 * idx(va, l);
  endfunction

  task automatic build(int top, int leafl, logic [63:0] va, logic [63:0] leaf_pte);
    mem.delete();
    for (int l = top; l > leafl; l--) mem[ent_addr(va, l)] = (tbl(l - 1) << 10) | 64'h1;
    mem[ent_addr(va, leafl)] = leaf_pte;
    cfg_root = tbl(top)[43:0];
    cfg_mode = 4'(top + 6);
  endtask

  // memory model
  initial begin
    logic [63:0] a;
    forever begin
      @(negedge clk);
      if (mreq_valid) begin
        if (mem_stall > 0) repeat (mem_stall) @(negedge clk);
        a = 64'(mreq_addr);
        if (reads == 0) first_addr = a;
        reads++;
        mreq_ready = 1'b1;
        @(negedge clk);
        mreq_ready = 1'b0;
        mrsp_data  = mem.exists(a) ? mem[a] : 64'h0;
        mrsp_valid = 1'b1;
        @(negedge clk);
        mrsp_valid = 1'b0;
      end
    end
  end

  task automatic walk(logic [63:0] va, bit hold);
    reads = 0;
    first_addr = '1;
    @(negedge clk);
    chk("R10 ready when idle", 64'(req_ready), 64'h1);
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 not ready when busy", 64'(req_ready), 64'h0);
    while (!rsp_valid) @(negedge clk);
    r_pa = 64'(rsp_pa); r_perm = 64'(rsp_perm); r_fault = 64'(rsp_fault);
    if (hold) begin
      repeat (2) @(negedge clk);
      chk("R10 response held", 64'(rsp_valid), 64'h1);
      chk("R10 response stable", 64'(rsp_pa), r_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 response drops after accept", 64'(rsp_valid), 64'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] va, p, pte, m, e;
    logic [6:0] perm;
    int top, k;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", 64'(req_ready), 64'h1);
    chk("R10 reset no response", 64'(rsp_valid), 64'h0);
    chk("R10 reset no memory request", 64'(mreq_valid), 64'h0);
    rst_n = 1'b1;

    // R1 R3 R5 R6 R9: every mode against every leaf level
    for (int md = 8; md <= 10; md++) begin
      top = md - 6;
      for (int lv = 0; lv <= top; lv++) begin
        k = md * 8 + lv;
        va = sx(64'h5A3C_96E1_7B24_D0F8 ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15), vaw(top));
        p = (64'hA5_C31E_97B2 + 64'(k) * 64'h1_0000_1357) & 64'hFFF_FFFF_FFFF;
        perm = 7'((k * 37) & 127) | 7'h1;
        if (md == 9 && lv == 0) perm = 7'b1110000;
        build(top, lv, va, (p << 10) | (64'(perm) << 1) | 64'h1);
        walk(va, lv == 1);
        m = (64'h1 << (12 + 9 * lv)) - 1;
        e = (((p << 12) & ~m) | (va & m)) & PA_MASK;
        chk("R6 leaf pa", r_pa, e);
        chk("R6 no fault on leaf", r_fault, 64'h0);
        chk("R9 permission bits", r_perm, 64'(perm));
        chk("R1 R5 read count", 64'(reads), 64'(top - lv + 1));
        chk("R3 first read address", first_addr, ent_addr(va, top));
      end
    end

    // R4: invalid entry at each depth
    for (int lv = 3; lv >= 0; lv--) begin
      va = sx(64'h0123_4567_89AB_CDEF + 64'(lv) * 64'h1111_1000, vaw(3));
      build(3, lv, va, (64'hABCDE << 10) | (64'h7F << 1));
      walk(va, 1'b0);
      chk("R4 invalid entry faults", r_fault, 64'h1);
      chk("R4 stops at invalid entry", 64'(reads), 64'(3 - lv + 1));
      chk("R9 fault pa zero", r_pa, 64'h0);
      chk("R9 fault perm zero", r_perm, 64'h0);
    end

    // R2: non-canonical addresses
    for (int md = 8; md <= 10; md++) begin
      top = md - 6;
      va = sx(64'hFEDC_BA98_7654_3210, vaw(top));
      build(top, 0, va, (64'h777 << 10) | 64'h3);
      walk(va ^ (64'h1 << 63), 1'b0);
      chk("R2 top bit flipped faults", r_fault, 64'h1);
      chk("R2 no read on non-canonical", 64'(reads), 64'h0);
      walk(va ^ (64'h1 << (vaw(top) - 1)), 1'b0);
      chk("R2 boundary bit flipped faults", r_fault, 64'h1);
      chk("R2 no read on boundary", 64'(reads), 64'h0);
    end

    // R1: unsupported mode codes
    foreach (k_list[i]) begin
      cfg_mode = k_list[i];
      walk(64'h0000_0000_1234_5000, 1'b0);
      chk("R1 bad mode faults", r_fault, 64'h1);
      chk("R1 bad mode no read", 64'(reads), 64'h0);
    end

    // R7: contiguous leaves, enable on and off
    p = 64'h9_8765_4321_3;
    for (int j = 0; j < 4; j++) begin
      va = sx(64'h0000_0012_3450_0ABC | (64'(j * 5) << 12), vaw(2));
      pte = (64'h1 << 63) | (p << 10) | (64'h5 << 1) | 64'h1;
      build(2, 0, va, pte);
      cfg_contig = 1'b1;
      walk(va, 1'b0);
      chk("R7 contiguous pa", r_pa, (((p >> 4) << 16) | (va & 64'hFFFF)) & PA_MASK);
      chk("R7 contiguous no fault", r_fault, 64'h0);
      cfg_contig = 1'b0;
      walk(va, 1'b0);
      chk("R7 flag ignored when disabled", r_pa, ((p << 12) | (va & 64'hFFF)) & PA_MASK);
    end

    // R8: flag above level 0
    cfg_contig = 1'b1;
    va = sx(64'h0000_0045_6789_A123, vaw(2));
    build(2, 1, va, (64'h1 << 63) | (64'h3000 << 10) | 64'h3);
    walk(va, 1'b0);
    chk("R8 flagged leaf at level 1 faults", r_fault, 64'h1);
    chk("R8 read count", 64'(reads), 64'h2);
    build(2, 0, va, (64'h3000 << 10) | 64'h3);
    mem[ent_addr(va, 2)] = mem[ent_addr(va, 2)] | (64'h1 << 63);
    walk(va, 1'b0);
    chk("R8 flagged pointer faults", r_fault, 64'h1);
    chk("R8 pointer read count", 64'(reads), 64'h1);
    cfg_contig = 1'b0;

    // R10: memory stall
    mem_stall = 3;
    va = sx(64'hF0F0_1234_5678_9ABC, vaw(4));
    p = 64'h123_4567_89AB;
    build(4, 0, va, (p << 10) | (64'h3 << 1) | 64'h1);
    walk(va, 1'b1);
    chk("R10 stalled walk pa", r_pa, ((p << 12) | (va & 64'hFFF)) & PA_MASK);
    chk("R10 stalled walk reads", 64'(reads), 64'h5);
    mem_stall = 0;

    finish_run();
  end

  logic [3:0] k_list [4] = '{4'd0, 4'd7, 4'd11, 4'd15};
endmodule